// File: doc/BRIEF.md
# Out-of-Order Response Scheduler

This block sits on the response path of one master port in a crossbar. Several slaves hand it responses, and it returns them to the master one at a time. Responses that carry the same ordering tag leave in the order their requests were issued. Responses with different tags, or with no tag, may overtake each other. The request side tells the block about each outstanding tagged transaction by giving its target slave and tag. The block keeps these pairs, oldest first, in a small recorder.

Each cycle, a fixed-priority selector picks one slave response. A comparator then checks it against the recorder. A tagged response is out of order when the oldest outstanding entry for its tag names a different slave. Such a response is parked in a one-entry loop slot, which wins over the slave inputs as soon as its turn comes. A response that is in order gets an urgency value from its tag. It then either goes straight to the master, when the holding queue is empty, or enters a four-entry priority queue that always releases its most urgent entry first. A policy input decides whether untagged traffic is the most urgent or the least urgent.

Top module: `rsp_scheduler`

## Requirements
- R1: When several slave inputs are eligible in the same cycle, the lowest-numbered slave is accepted, and at most one `sReady` bit is high in any cycle.
- R2: A request is recorded when `reqValid` and `reqReady` are both high. `reqReady` is low while REC_DEPTH entries are outstanding.
- R3: A tagged response is out of order when the oldest outstanding entry with the same tag names another slave. Such a response is accepted into the loop slot and is not shown to the master in that cycle or while it stays out of order.
- R4: While the loop slot holds a response that is now in order, that response is taken before any slave input, and every `sReady` bit is low. While the loop slot holds an out-of-order response, only in-order slave responses are accepted.
- R5: The urgency of a tagged response is its tag + 1. An untagged response gets urgency 0 when `oooFirst` = 0 and 2^(TAG_W+1)-1 when `oooFirst` = 1. The smaller value leaves first, and equal values leave in arrival order.
- R6: For every tag, responses reach the master in the order their requests were recorded. No response is lost or duplicated.
- R7: When the queue is empty, an in-order response appears on `mValid`/`mData` in the same cycle it is presented.
- R8: The queue holds Q_DEPTH responses. When the queue is full and no response can be delivered directly, in-order slave responses are refused. `mValid` stays high while `mReady` is low.
- R9: During and right after reset, `mValid` and all `sReady` bits are low and `reqReady` is high.
- R10: The recorder entry of a tagged response is freed in the cycle that response is delivered or queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oooFirst | input | 1 | 1: untagged responses are least urgent; 0: most urgent |
| reqValid | input | 1 | Record a new outstanding tagged transaction |
| reqSlave | input | SLV_W | Target slave of the recorded transaction |
| reqTag | input | TAG_W | Tag of the recorded transaction |
| reqReady | output | 1 | Recorder has room |
| sValid | input | NUM_SLV | Per-slave response valid |
| sTagged | input | NUM_SLV | Per-slave flag: the response carries a tag |
| sTag | input | NUM_SLV*TAG_W | Per-slave response tags, slave i at bits [i*TAG_W +: TAG_W] |
| sData | input | NUM_SLV*DATA_W | Per-slave response data, slave i at bits [i*DATA_W +: DATA_W] |
| sReady | output | NUM_SLV | Per-slave response accepted |
| mValid | output | 1 | Response to master valid |
| mReady | input | 1 | Master accepts the response |
| mSlave | output | SLV_W | Slave that produced the response |
| mTagged | output | 1 | Response carries a tag |
| mTag | output | TAG_W | Response tag |
| mData | output | DATA_W | Response data |

## Verification
The bench works out when each result is due. A response that takes the direct path shows on the master port in the same cycle it is presented, so the check reads it at the falling edge of that cycle. A response parked in the loop slot can leave no earlier than the cycle after the response it waits for has been accepted. Queued responses leave one per cycle with `mReady` high, most urgent first. A recorder entry is freed at the clock edge that accepts its response, so `reqReady` is checked one falling edge later. The scoreboard pops an expected item only on a handshake seen at a falling edge, either in one global order for the directed cases or per tag for the random-latency run.

// File: rtl/rsp_sched_pkg.sv
package rsp_sched_pkg;
  // Strobes from the control to the storage elements.
  typedef struct packed {
    logic loopLoad;  // park an out-of-order response
    logic loopDrop;  // loop slot content has left
    logic enq;       // write candidate into priority queue
    logic deq;       // master took the queue head
    logic retire;    // free the recorder entry of the candidate
  } schedStrobe_t;
endpackage

// File: rtl/rsp_recorder.sv
module rsp_recorder #(
  parameter int NUM_SLV   = 3,
  parameter int TAG_W     = 2,
  parameter int REC_DEPTH = 8,
  parameter int SLV_W     = 2,
  localparam int NQ       = NUM_SLV + 1,
  localparam int CNT_W    = $clog2(REC_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                appendValid,
  input  logic [SLV_W-1:0]    appendSlave,
  input  logic [TAG_W-1:0]    appendTag,
  input  logic                retire,
  input  logic [SLV_W-1:0]    retireSlave,
  input  logic [TAG_W-1:0]    retireTag,
  input  logic [NQ*SLV_W-1:0] qSlave,
  input  logic [NQ*TAG_W-1:0] qTag,
  input  logic [NQ-1:0]       qTagged,
  output logic [NQ-1:0]       qViol,
  output logic                full,
  output logic [CNT_W-1:0]    count
);
  logic [SLV_W-1:0] entSlave [REC_DEPTH];
  logic [TAG_W-1:0] entTag   [REC_DEPTH];
  logic [SLV_W-1:0] nSlave   [REC_DEPTH];
  logic [TAG_W-1:0] nTag     [REC_DEPTH];
  logic [CNT_W-1:0] cnt, cntMid;
  logic [CNT_W-1:0] remIdx;
  logic             remHit;

  assign full  = (cnt == CNT_W'(REC_DEPTH));
  assign count = cnt;

  // One comparator per query slot: the oldest entry with the same tag decides.
  for (genvar q = 0; q < NQ; q++) begin : g_cmp
    logic found, differ;
    always_comb begin
      found  = 1'b0;
      differ = 1'b0;
      for (int i = 0; i < REC_DEPTH; i++) begin
        if (!found && CNT_W'(i) < cnt && entTag[i] == qTag[q*TAG_W +: TAG_W]) begin
          found  = 1'b1;
          differ = (entSlave[i] != qSlave[q*SLV_W +: SLV_W]);
        end
      end
      qViol[q] = qTagged[q] && found && differ;
    end
  end

  always_comb begin
    remHit = 1'b0;
    remIdx = '0;
    for (int i = 0; i < REC_DEPTH; i++) begin
      if (retire && !remHit && CNT_W'(i) < cnt &&
          entTag[i] == retireTag && entSlave[i] == retireSlave) begin
        remHit = 1'b1;
        remIdx = CNT_W'(i);
      end
    end
  end

  always_comb begin
    nSlave = entSlave;
    nTag   = entTag;
    for (int i = 0; i < REC_DEPTH - 1; i++) begin
      if (remHit && CNT_W'(i) >= remIdx) begin
        nSlave[i] = entSlave[i+1];
        nTag[i]   = entTag[i+1];
      end
    end
    cntMid = cnt - CNT_W'(remHit);
    for (int i = 0; i < REC_DEPTH; i++) begin
      if (appendValid && CNT_W'(i) == cntMid) begin
        nSlave[i] = appendSlave;
        nTag[i]   = appendTag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      for (int i = 0; i < REC_DEPTH; i++) begin
        entSlave[i] <= '0;
        entTag[i]   <= '0;
      end
    end else begin
      cnt      <= cntMid + CNT_W'(appendValid);
      entSlave <= nSlave;
      entTag   <= nTag;
    end
  end
endmodule

// File: rtl/rsp_prio_queue.sv
module rsp_prio_queue #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 3,
  parameter int PAY_W  = 21,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enq,
  input  logic [PRIO_W-1:0] enqPrio,
  input  logic [PAY_W-1:0]  enqPay,
  input  logic              deq,
  output logic              empty,
  output logic              full,
  output logic [PAY_W-1:0]  headPay,
  output logic [CNT_W-1:0]  count
);
  logic [PRIO_W-1:0] prio  [DEPTH];
  logic [PAY_W-1:0]  pay   [DEPTH];
  logic [PRIO_W-1:0] nPrio [DEPTH];
  logic [PAY_W-1:0]  nPay  [DEPTH];
  logic [CNT_W-1:0]  cnt, cntMid;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic              have;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign count   = cnt;
  assign headPay = pay[bestIdx];

  // Smallest urgency value wins; strict compare keeps the oldest among equals.
  always_comb begin
    have     = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < cnt && (!have || prio[i] < bestPrio)) begin
        have     = 1'b1;
        bestIdx  = IDX_W'(i);
        bestPrio = prio[i];
      end
    end
  end

  always_comb begin
    nPrio = prio;
    nPay  = pay;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (deq && IDX_W'(i) >= bestIdx) begin
        nPrio[i] = prio[i+1];
        nPay[i]  = pay[i+1];
      end
    end
    cntMid = cnt - CNT_W'(deq);
    for (int i = 0; i < DEPTH; i++) begin
      if (enq && CNT_W'(i) == cntMid) begin
        nPrio[i] = enqPrio;
        nPay[i]  = enqPay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio[i] <= '0;
        pay[i]  <= '0;
      end
    end else begin
      cnt  <= cntMid + CNT_W'(enq);
      prio <= nPrio;
      pay  <= nPay;
    end
  end
endmodule

// File: rtl/rsp_sched_ctrl.sv
module rsp_sched_ctrl
  import rsp_sched_pkg::*;
#(
  parameter int NUM_SLV = 3,
  parameter int TAG_W   = 2,
  parameter int DATA_W  = 16,
  parameter int SLV_W   = 2,
  localparam int PRIO_W = TAG_W + 1,
  localparam int PAY_W  = SLV_W + 1 + TAG_W + DATA_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      oooFirst,
  input  logic [NUM_SLV-1:0]        sValid,
  input  logic [NUM_SLV-1:0]        sTagged,
  input  logic [NUM_SLV*TAG_W-1:0]  sTag,
  input  logic [NUM_SLV*DATA_W-1:0] sData,
  input  logic [NUM_SLV-1:0]        slvViol,
  input  logic                      loopViol,
  input  logic                      qEmpty,
  input  logic                      qFull,
  input  logic [PAY_W-1:0]          qHeadPay,
  input  logic                      mReady,
  output logic [NUM_SLV-1:0]        sReady,
  output logic                      mValid,
  output logic [PAY_W-1:0]          mPay,
  output logic                      loopValid,
  output logic [SLV_W-1:0]          loopSlave,
  output logic [TAG_W-1:0]          loopTag,
  output logic                      loopTagged,
  output logic [PAY_W-1:0]          candPay,
  output logic [PRIO_W-1:0]         candPrio,
  output schedStrobe_t              strobe
);
  logic [PAY_W-1:0] slvPay [NUM_SLV];
  logic [PAY_W-1:0] loopPay;
  logic [SLV_W-1:0] pickIdx;
  logic             pickValid, useLoop, candValid, candViol, candOk;
  logic             bypassGo, enqGo, taken;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_pay
    assign slvPay[i] = {SLV_W'(i), sTagged[i], sTag[i*TAG_W +: TAG_W], sData[i*DATA_W +: DATA_W]};
  end

  assign loopSlave  = loopPay[PAY_W-1 -: SLV_W];
  assign loopTagged = loopPay[DATA_W + TAG_W];
  assign loopTag    = loopPay[DATA_W +: TAG_W];

  // First selector: lowest slave index wins; slaves still out of order are
  // skipped while the loop slot is occupied.
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = '0;
    for (int i = NUM_SLV - 1; i >= 0; i--) begin
      if (sValid[i] && (!loopValid || !slvViol[i])) begin
        pickValid = 1'b1;
        pickIdx   = SLV_W'(i);
      end
    end
  end

  // Second selector: the loop slot is preferred once its response is in order.
  always_comb begin
    useLoop   = loopValid && !loopViol;
    candValid = useLoop || pickValid;
    candPay   = useLoop ? loopPay : slvPay[pickIdx];
    candViol  = !loopValid && pickValid && slvViol[pickIdx];
    candOk    = candValid && !candViol;
    bypassGo  = qEmpty && candOk && mReady;
    enqGo     = candOk && !bypassGo && !qFull;
    taken     = bypassGo || enqGo;
    if (candPay[DATA_W + TAG_W])
      candPrio = {1'b0, candPay[DATA_W +: TAG_W]} + PRIO_W'(1);
    else
      candPrio = oooFirst ? '1 : '0;
  end

  always_comb begin
    for (int i = 0; i < NUM_SLV; i++)
      sReady[i] = !useLoop && pickValid && pickIdx == SLV_W'(i) && (candViol || taken);
    mValid          = qEmpty ? candOk : 1'b1;
    mPay            = qEmpty ? candPay : qHeadPay;
    strobe.loopLoad = candViol;
    strobe.loopDrop = useLoop && taken;
    strobe.enq      = enqGo;
    strobe.deq      = !qEmpty && mReady;
    strobe.retire   = taken && candPay[DATA_W + TAG_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loopValid <= 1'b0;
      loopPay   <= '0;
    end else if (strobe.loopLoad) begin
      loopValid <= 1'b1;
      loopPay   <= candPay;
    end else if (strobe.loopDrop) begin
      loopValid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsp_scheduler.sv
module rsp_scheduler
  import rsp_sched_pkg::*;
#(
  parameter int NUM_SLV   = 3,
  parameter int TAG_W     = 2,
  parameter int DATA_W    = 16,
  parameter int REC_DEPTH = 8,
  parameter int Q_DEPTH   = 4,
  localparam int SLV_W    = $clog2(NUM_SLV),
  localparam int PRIO_W   = TAG_W + 1,
  localparam int PAY_W    = SLV_W + 1 + TAG_W + DATA_W,
  localparam int NQ       = NUM_SLV + 1,
  localparam int REC_CNT_W = $clog2(REC_DEPTH + 1),
  localparam int Q_CNT_W  = $clog2(Q_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      oooFirst,
  input  logic                      reqValid,
  input  logic [SLV_W-1:0]          reqSlave,
  input  logic [TAG_W-1:0]          reqTag,
  output logic                      reqReady,
  input  logic [NUM_SLV-1:0]        sValid,
  input  logic [NUM_SLV-1:0]        sTagged,
  input  logic [NUM_SLV*TAG_W-1:0]  sTag,
  input  logic [NUM_SLV*DATA_W-1:0] sData,
  output logic [NUM_SLV-1:0]        sReady,
  output logic                      mValid,
  input  logic                      mReady,
  output logic [SLV_W-1:0]          mSlave,
  output logic                      mTagged,
  output logic [TAG_W-1:0]          mTag,
  output logic [DATA_W-1:0]         mData
);
  schedStrobe_t          strobe;
  logic [NQ*SLV_W-1:0]   qSlave;
  logic [NQ*TAG_W-1:0]   qTag;
  logic [NQ-1:0]         qTagged, qViol;
  logic [NUM_SLV-1:0]    slvViol;
  logic                  loopViol, loopValid, loopTagged;
  logic [SLV_W-1:0]      loopSlave;
  logic [TAG_W-1:0]      loopTag;
  logic                  recFull, qEmpty, qFull;
  logic [REC_CNT_W-1:0]  recCount;
  logic [Q_CNT_W-1:0]    qCount;
  logic [PAY_W-1:0]      candPay, qHeadPay, mPay;
  logic [PRIO_W-1:0]     candPrio;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_query
    assign qSlave[i*SLV_W +: SLV_W] = SLV_W'(i);
  end
  assign qSlave[NUM_SLV*SLV_W +: SLV_W] = loopSlave;
  assign qTag    = {loopTag, sTag};
  assign qTagged = {loopTagged, sTagged};
  assign slvViol  = qViol[NUM_SLV-1:0];
  assign loopViol = qViol[NUM_SLV];
  assign reqReady = !recFull;
  assign {mSlave, mTagged, mTag, mData} = mPay;

  rsp_recorder #(
    .NUM_SLV(NUM_SLV), .TAG_W(TAG_W), .REC_DEPTH(REC_DEPTH), .SLV_W(SLV_W)
  ) uRec (
    .clk(clk), .rstN(rstN),
    .appendValid(reqValid && !recFull), .appendSlave(reqSlave), .appendTag(reqTag),
    .retire(strobe.retire),
    .retireSlave(candPay[PAY_W-1 -: SLV_W]), .retireTag(candPay[DATA_W +: TAG_W]),
    .qSlave(qSlave), .qTag(qTag), .qTagged(qTagged), .qViol(qViol),
    .full(recFull), .count(recCount)
  );

  rsp_prio_queue #(
    .DEPTH(Q_DEPTH), .PRIO_W(PRIO_W), .PAY_W(PAY_W)
  ) uQueue (
    .clk(clk), .rstN(rstN),
    .enq(strobe.enq), .enqPrio(candPrio), .enqPay(candPay), .deq(strobe.deq),
    .empty(qEmpty), .full(qFull), .headPay(qHeadPay), .count(qCount)
  );

  rsp_sched_ctrl #(
    .NUM_SLV(NUM_SLV), .TAG_W(TAG_W), .DATA_W(DATA_W), .SLV_W(SLV_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .oooFirst(oooFirst),
    .sValid(sValid), .sTagged(sTagged), .sTag(sTag), .sData(sData),
    .slvViol(slvViol), .loopViol(loopViol),
    .qEmpty(qEmpty), .qFull(qFull), .qHeadPay(qHeadPay), .mReady(mReady),
    .sReady(sReady), .mValid(mValid), .mPay(mPay),
    .loopValid(loopValid), .loopSlave(loopSlave), .loopTag(loopTag), .loopTagged(loopTagged),
    .candPay(candPay), .candPrio(candPrio), .strobe(strobe)
  );
endmodule

// File: rtl/rsp_sched_checker.sv
module rsp_sched_checker
  import rsp_sched_pkg::*;
#(
  parameter int NUM_SLV   = 3,
  parameter int REC_DEPTH = 8,
  parameter int Q_DEPTH   = 4,
  parameter int REC_CNT_W = 4,
  parameter int Q_CNT_W   = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLV-1:0]   sValid,
  input logic [NUM_SLV-1:0]   sReady,
  input logic [NUM_SLV-1:0]   sTagged,
  input logic [NUM_SLV-1:0]   slvViol,
  input logic                 loopValid,
  input logic                 loopViol,
  input schedStrobe_t         strobe,
  input logic                 qFull,
  input logic [Q_CNT_W-1:0]   qCount,
  input logic                 mValid,
  input logic                 mReady,
  input logic                 reqReady,
  input logic [REC_CNT_W-1:0] recCount
);
  assert_ready_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sReady));

  for (genvar j = 1; j < NUM_SLV; j++) begin : g_prio
    for (genvar i = 0; i < j; i++) begin : g_low
      assert_slave_prio_R1: assert property (@(posedge clk) disable iff (!rstN)
        (sReady[j] && sValid[i]) |-> (loopValid && slvViol[i]));
    end
  end

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_untag
    // R5: untagged traffic is in order by definition
    assert_untagged_in_order_R5: assert property (@(posedge clk) disable iff (!rstN)
      (sValid[i] && !sTagged[i]) |-> !slvViol[i]);
  end

  assert_rec_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    (recCount == REC_CNT_W'(REC_DEPTH)) |-> !reqReady);

  assert_viol_parked_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loopLoad |=> loopValid);

  assert_loop_pref_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loopValid && !loopViol) |-> (sReady == '0));

  assert_loop_leaves_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loopDrop |=> !loopValid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= Q_CNT_W'(Q_DEPTH));

  assert_no_enq_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enq |-> !qFull);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !mReady) |=> mValid);

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (qFull && !mReady && loopValid) |-> (sReady == '0));

  assert_deq_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.deq |-> (mValid && mReady));

  assert_retire_on_take_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |-> (strobe.enq || (mValid && mReady)));
endmodule

bind rsp_scheduler rsp_sched_checker #(
  .NUM_SLV(NUM_SLV), .REC_DEPTH(REC_DEPTH), .Q_DEPTH(Q_DEPTH),
  .REC_CNT_W(REC_CNT_W), .Q_CNT_W(Q_CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady), .sTagged(sTagged),
  .slvViol(slvViol), .loopValid(loopValid), .loopViol(loopViol), .strobe(strobe),
  .qFull(qFull), .qCount(qCount), .mValid(mValid), .mReady(mReady),
  .reqReady(reqReady), .recCount(recCount)
);

// File: tb/tb_rsp_scheduler.sv
`timescale 1ns/1ps
module tb_rsp_scheduler;
  localparam int NS = 3, TW = 2, DW = 16, RD = 8, QD = 4, SW = 2, NT = 4;
  localparam int N_RAND = 300;

  logic clk = 0, rstN = 0, oooFirst = 0;
  logic reqValid = 0, reqReady;
  logic [SW-1:0] reqSlave = 0;
  logic [TW-1:0] reqTag = 0;
  logic [NS-1:0] sValid = 0, sTagged = 0, sReady;
  logic [NS*TW-1:0] sTag = 0;
  logic [NS*DW-1:0] sData = 0;
  logic mValid, mReady = 0, mTagged;
  logic [SW-1:0] mSlave;
  logic [TW-1:0] mTag;
  logic [DW-1:0] mData;

  always #2.5 clk = ~clk;

  rsp_scheduler #(.NUM_SLV(NS), .TAG_W(TW), .DATA_W(DW), .REC_DEPTH(RD), .Q_DEPTH(QD)) dut (
    .clk(clk), .rstN(rstN), .oooFirst(oooFirst),
    .reqValid(reqValid), .reqSlave(reqSlave), .reqTag(reqTag), .reqReady(reqReady),
    .sValid(sValid), .sTagged(sTagged), .sTag(sTag), .sData(sData), .sReady(sReady),
    .mValid(mValid), .mReady(mReady), .mSlave(mSlave), .mTagged(mTagged),
    .mTag(mTag), .mData(mData));

  int nChecks = 0, nFails = 0, nDelivered = 0;
  bit strictMode = 1, finished = 0;
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] tagQ[NT][$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Monitor: every handshake is compared with the scoreboard.
  always @(negedge clk) begin
    if (rstN && mValid && mReady) begin
      nDelivered++;
      if (strictMode) begin
        if (expQ.size() == 0) check(0, "R6 unexpected response", int'(mData), 0);
        else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          check(mData == e, "R6 order", int'(mData), int'(e));
        end
      end else if (mTagged) begin
        if (tagQ[mTag].size() == 0) check(0, "R6 duplicate", int'(mData), 0);
        else begin
          logic [DW-1:0] e;
          e = tagQ[mTag].pop_front();
          check(mData == e, "R6 per-tag order", int'(mData), int'(e));
        end
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic doReq(input int s, input int t);
    reqValid = 1; reqSlave = SW'(s); reqTag = TW'(t);
    forever begin @(negedge clk); if (reqReady) break; end
    tick(); reqValid = 0;
  endtask

  task automatic present(input int s, input bit tg, input int t, input int d);
    sValid[s] = 1; sTagged[s] = tg;
    sTag[s*TW +: TW] = TW'(t); sData[s*DW +: DW] = DW'(d);
  endtask

  task automatic sendRsp(input int s, input bit tg, input int t, input int d);
    present(s, tg, t, d);
    for (int k = 0; k < 200; k++) begin @(negedge clk); if (sReady[s]) break; end
    tick(); sValid[s] = 0;
  endtask

  task automatic drain(input string req);
    int k;
    for (k = 0; k < 500 && expQ.size() != 0; k++) tick();
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  // Random-latency slave models
  int pendId[NS][$];
  int pendTag[NS][$];
  int lat[NS];

  task automatic randomRun();
    int issued = 0, nextId = 'h4000, cyc = 0;
    bit reqFire;
    bit sFire[NS];
    strictMode = 0;
    nDelivered = 0;
    for (int i = 0; i < NS; i++) lat[i] = 0;
    while ((issued < N_RAND || nDelivered < N_RAND) && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      reqFire = reqValid && reqReady;
      for (int i = 0; i < NS; i++) sFire[i] = sValid[i] && sReady[i];
      tick();
      if (reqFire) begin
        pendId[reqSlave].push_back(nextId);
        pendTag[reqSlave].push_back(int'(reqTag));
        tagQ[reqTag].push_back(DW'(nextId));
        nextId++; issued++;
      end
      for (int i = 0; i < NS; i++) if (sFire[i]) begin
        void'(pendId[i].pop_front()); void'(pendTag[i].pop_front());
        lat[i] = int'($urandom_range(0, 5));
      end
      reqValid = (issued < N_RAND) && ($urandom_range(0, 3) != 0);
      reqSlave = SW'($urandom_range(0, NS - 1));
      reqTag   = TW'($urandom_range(0, NT - 1));
      for (int i = 0; i < NS; i++) begin
        if (pendId[i].size() != 0 && lat[i] == 0) present(i, 1, pendTag[i][0], pendId[i][0]);
        else begin
          sValid[i] = 0;
          if (lat[i] > 0) lat[i]--;
        end
      end
      mReady = ($urandom_range(0, 3) != 0);
    end
    check(nDelivered == N_RAND, "R6 no loss", nDelivered, N_RAND);
    for (int t = 0; t < NT; t++) check(tagQ[t].size() == 0, "R6 leftover", tagQ[t].size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    report();
  end

  initial begin
    // Reset state (R9)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mValid == 0, "R9 mValid in reset", mValid, 0);
    check(sReady == 0, "R9 sReady in reset", sReady, 0);
    tick(); rstN = 1;
    @(negedge clk);
    check(mValid == 0 && sReady == 0, "R9 idle after reset", {mValid, sReady}, 0);
    check(reqReady == 1, "R9 reqReady after reset", reqReady, 1);
    tick();

    // Direct path with an empty queue (R7)
    mReady = 1;
    doReq(1, 1);
    expQ.push_back('h101);
    present(1, 1, 1, 'h101);
    @(negedge clk);
    check(mValid == 1 && mData == 'h101, "R7 same-cycle bypass", int'(mData), 'h101);
    check(sReady == 3'b010, "R7 slave accepted", sReady, 3'b010);
    tick(); sValid = 0;
    drain("R7 drained");

    // Urgency order, untagged first (R5)
    oooFirst = 0; mReady = 0;
    doReq(0, 3); doReq(1, 1);
    sendRsp(0, 1, 3, 'hA1); sendRsp(1, 1, 1, 'hA2); sendRsp(2, 0, 0, 'hA3);
    expQ.push_back('hA3); expQ.push_back('hA2); expQ.push_back('hA1);
    tick(); mReady = 1;
    drain("R5 in-order-first drain");

    // Urgency order, untagged last (R5)
    oooFirst = 1; mReady = 0;
    doReq(0, 3); doReq(1, 1);
    sendRsp(2, 0, 0, 'hB3); sendRsp(0, 1, 3, 'hB1); sendRsp(1, 1, 1, 'hB2);
    expQ.push_back('hB2); expQ.push_back('hB1); expQ.push_back('hB3);
    tick(); mReady = 1;
    drain("R5 out-of-order-first drain");
    oooFirst = 0;

    // Out-of-order response parked, then loop slot preferred (R3, R4)
    doReq(1, 0); doReq(0, 0);
    expQ.push_back('hC2); expQ.push_back('hC1); expQ.push_back('hD1);
    present(0, 1, 0, 'hC1);
    @(negedge clk);
    check(sReady[0] == 1 && mValid == 0, "R3 parked not shown", {sReady[0], mValid}, 2'b10);
    tick(); sValid[0] = 0;
    @(negedge clk);
    check(mValid == 0, "R3 still waiting", mValid, 0);
    tick(); present(1, 1, 0, 'hC2);
    @(negedge clk);
    check(mValid == 1 && mData == 'hC2, "R3 older response first", int'(mData), 'hC2);
    check(sReady[1] == 1, "R4 in-order slave accepted while loop waits", sReady[1], 1);
    tick(); sValid[1] = 0; present(2, 0, 0, 'hD1);
    @(negedge clk);
    check(mValid == 1 && mData == 'hC1, "R4 loop slot delivered", int'(mData), 'hC1);
    check(sReady == 0, "R4 slaves held while loop leaves", sReady, 0);
    tick();
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (sReady[2]) break; end
    tick(); sValid[2] = 0;
    drain("R4 drained");

    // Fixed slave priority (R1)
    expQ.push_back('hE0); expQ.push_back('hE2);
    present(0, 0, 0, 'hE0); present(2, 0, 0, 'hE2);
    @(negedge clk);
    check(sReady == 3'b001, "R1 lowest slave wins", sReady, 3'b001);
    check(mData == 'hE0, "R1 winner data", int'(mData), 'hE0);
    tick(); sValid[0] = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (sReady[2]) break; end
    tick(); sValid[2] = 0;
    drain("R1 drained");

    // Queue full backpressure (R8)
    mReady = 0;
    for (int i = 0; i < QD; i++) begin
      sendRsp(0, 0, 0, 'hF0 + i);
      expQ.push_back(DW'('hF0 + i));
    end
    present(0, 0, 0, 'hF9);
    expQ.push_back('hF9);
    repeat (2) @(negedge clk);
    check(sReady[0] == 0, "R8 refused when full", sReady[0], 0);
    check(mValid == 1, "R8 valid held", mValid, 1);
    tick(); mReady = 1;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (sReady[0]) break; end
    tick(); sValid[0] = 0;
    drain("R8 drained");

    // Recorder capacity and freeing (R2, R10)
    for (int i = 0; i < RD; i++) doReq(0, i % NT);
    @(negedge clk);
    check(reqReady == 0, "R2 recorder full", reqReady, 0);
    tick();
    expQ.push_back('h300);
    sendRsp(0, 1, 0, 'h300);
    @(negedge clk);
    check(reqReady == 1, "R10 entry freed", reqReady, 1);
    tick();
    for (int i = 1; i < RD; i++) begin
      expQ.push_back(DW'('h300 + i));
      sendRsp(0, 1, i % NT, 'h300 + i);
    end
    drain("R10 drained");

    // Random latencies, per-tag order (R6)
    randomRun();
    report();
  end
endmodule